// File: doc/BRIEF.md
# Current-Mode PWM Gate Timing Generator

This block turns a stream of single-cycle oscillator ticks into the gate-drive pulse of a single-switch power converter. A switching period is two ticks long in the half-duty variant and four ticks long in the three-quarter-duty variant. The gate rises at the start of each period and is allowed to stay high for one or three tick intervals respectively. Within that window it is cut short by any of three things: a digitized PWM-compare flag, a digitized current-limit flag, or a programmable dead time that trims the end of the last allowed interval.

The PWM-compare flag is masked for a fixed number of clock cycles after each rising edge. This keeps the switching spike from ending the pulse early. The current-limit flag is never masked and removes the gate in the same cycle it is seen. Once the gate has fallen it stays low until the next period starts. An external sync tick can replace the oscillator tick. The block does this only after a simple interval comparison shows that the sync source is at least 25% faster; otherwise it keeps using the internal ticks. All control and status pins are plain levels or single-cycle pulses. There is no streamed data path, so no valid/ready handshake applies.

Top module: `pwm_gate_timer`

## Requirements
- R1: While reset is asserted, gate and ilim_pulse are 0.
- R2: With duty_mode=0 (half duty), pwm_trip, ilim_trip and dead_cnt all 0, and ticks every L cycles, the gate rises once per 2 tick intervals (period 2L cycles) and is high for L cycles. Rising edges follow only the tick that opens a period.
- R3: With duty_mode=1 (three-quarter duty) and no trips, the period is 4L cycles and the gate is high for 3L cycles.
- R4: For BLANK_CYC cycles after a rising edge, pwm_trip is ignored. If pwm_trip is held from the first high cycle, the gate is high for exactly BLANK_CYC+1 cycles.
- R5: Outside the blanking window, pwm_trip sampled at a clock edge makes gate 0 from that edge on.
- R6: ilim_trip drives gate to 0 in the same cycle, including inside the blanking window. ilim_pulse is 1 for one cycle right after the first edge that samples ilim_trip while the gate is on.
- R7: After the gate has fallen within a period, it stays 0 until the next period starts, even when every flag clears.
- R8: A nonzero dead_cnt=D shortens the last allowed tick interval of the on-time by D cycles, using the length of the previous tick interval. The blanking window still sets the minimum on-time. D=0 gives the full maximum on-time.
- R9: While enable is 0, gate is 0 in the same cycle and no rising edge occurs.
- R10: With sync_sel=1, sync ticks drive the period only when the measured sync interval times 5 is no more than the oscillator interval times 4. Otherwise the oscillator ticks keep driving it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; 0 holds the gate off |
| osc_tick | input | 1 | Internal oscillator tick, one cycle wide |
| sync_tick | input | 1 | External sync tick, one cycle wide |
| sync_sel | input | 1 | 1 requests the sync tick as period source |
| duty_mode | input | 1 | 0: two-tick period, 1: four-tick period |
| pwm_trip | input | 1 | Digitized PWM-compare flag (blanked) |
| ilim_trip | input | 1 | Digitized current-limit flag (never blanked) |
| dead_cnt | input | DT_W | Dead time in clock cycles |
| gate | output | 1 | Gate-drive output |
| ilim_pulse | output | 1 | One-cycle marker of a current-limit trip |

## Verification
A wrong period phase shows as a gate rise on the wrong tick, and a wrong period length, within one switching period of the fault. A stale or miscounted blanking counter changes the length of a pulse that a held pwm_trip cuts short, which shows in the very next pulse. A bad interval measurement shows in two ways: a dead-time trim of the wrong size, or a sync selection that is wrongly taken or refused. Both appear as pulse widths that differ by whole cycles once two ticks of the affected source have passed.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;

  typedef enum logic {
    DUTY_HALF  = 1'b0,
    DUTY_THREE = 1'b1
  } duty_mode_e;

  // index of the last tick interval in a switching period
  function automatic logic [1:0] period_last(duty_mode_e m);
    return (m == DUTY_THREE) ? 2'd3 : 2'd1;
  endfunction

  // index of the last tick interval the gate may be high in
  function automatic logic [1:0] on_last(duty_mode_e m);
    return (m == DUTY_THREE) ? 2'd2 : 2'd0;
  endfunction

endpackage

// File: rtl/pwm_interval_meter.sv
module pwm_interval_meter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] run,
  output logic [CNT_W-1:0] len,
  output logic             valid
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= CNT_MAX;
      len    <= CNT_MAX;
      seen_q <= 2'd0;
    end else if (tick) begin
      run    <= '0;
      len    <= (run == CNT_MAX) ? CNT_MAX : run + 1'b1;
      seen_q <= (seen_q == 2'd2) ? 2'd2 : seen_q + 2'd1;
    end else if (run != CNT_MAX) begin
      run <= run + 1'b1;
    end
  end

  assign valid = (seen_q == 2'd2);

endmodule

// File: rtl/pwm_tick_select.sv
module pwm_tick_select #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic sync_tick,
  input  logic sync_sel,
  output logic eff_tick
);

  localparam int LW  = CNT_W + 3;
  localparam int NSRC = 2;   // 0: oscillator, 1: sync

  logic [NSRC-1:0]  src_tick;
  logic [CNT_W-1:0] src_run   [NSRC];
  logic [CNT_W-1:0] src_len   [NSRC];
  logic [CNT_W-1:0] src_worst [NSRC];
  logic [NSRC-1:0]  src_valid;
  logic             lock_q;
  logic [LW-1:0]    sync_scaled, osc_scaled;

  assign src_tick = {sync_tick, osc_tick};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    pwm_interval_meter #(.CNT_W(CNT_W)) u_meter (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (src_tick[i]),
      .run   (src_run[i]),
      .len   (src_len[i]),
      .valid (src_valid[i])
    );
    // a source that has gone quiet looks as slow as its running count
    assign src_worst[i] = (src_run[i] > src_len[i]) ? src_run[i] : src_len[i];
  end

  assign sync_scaled = LW'(src_worst[1]) * LW'(5);
  assign osc_scaled  = LW'(src_worst[0]) * LW'(4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= &src_valid && (sync_scaled <= osc_scaled);
  end

  assign eff_tick = (sync_sel && lock_q) ? sync_tick : osc_tick;

endmodule

// File: rtl/pwm_phase_seq.sv
module pwm_phase_seq
  import pwm_gate_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  duty_mode_e       mode,
  output logic             period_start,
  output logic             off_tick,
  output logic             final_on,
  output logic [CNT_W-1:0] cyc,
  output logic [CNT_W-1:0] last_len,
  output logic             len_valid
);

  logic [1:0] phase_q, phase_nxt, last_idx, on_idx;

  assign last_idx  = period_last(mode);
  assign on_idx    = on_last(mode);
  assign phase_nxt = (phase_q >= last_idx) ? 2'd0 : phase_q + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= 2'd3;
    else if (!enable) phase_q <= 2'd3;
    else if (tick)    phase_q <= phase_nxt;
  end

  assign period_start = tick && enable && (phase_q >= last_idx);
  assign off_tick     = tick && (phase_nxt > on_idx);
  assign final_on     = (phase_q == on_idx);

  pwm_interval_meter #(.CNT_W(CNT_W)) u_len (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .run   (cyc),
    .len   (last_len),
    .valid (len_valid)
  );

endmodule

// File: rtl/pwm_gate_ctl.sv
module pwm_gate_ctl #(
  parameter int CNT_W     = 16,
  parameter int DT_W      = 8,
  parameter int BLANK_CYC = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             period_start,
  input  logic             off_tick,
  input  logic             final_on,
  input  logic [CNT_W-1:0] cyc,
  input  logic [CNT_W-1:0] last_len,
  input  logic             len_valid,
  input  logic [DT_W-1:0]  dead_cnt,
  input  logic             pwm_trip,
  input  logic             ilim_trip,
  output logic             gate_q,
  output logic             gate,
  output logic             ilim_pulse
);

  localparam int BLANK_W = $clog2(BLANK_CYC + 1);
  localparam logic [BLANK_W-1:0] BLANK_INIT = BLANK_W'(BLANK_CYC);
  localparam int SW = CNT_W + 2;

  logic [BLANK_W-1:0] blank_q;
  logic               blank_done, dead_hit, cut;
  logic [SW-1:0]      reach;

  assign blank_done = (blank_q == '0);
  assign reach      = SW'(cyc) + SW'(dead_cnt) + SW'(1);
  assign dead_hit   = final_on && len_valid && (dead_cnt != '0) && (reach >= SW'(last_len));
  assign cut        = off_tick || ilim_trip || (blank_done && (pwm_trip || dead_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q     <= 1'b0;
      ilim_pulse <= 1'b0;
    end else begin
      ilim_pulse <= ilim_trip && gate_q && enable;
      if (!enable)              gate_q <= 1'b0;
      else if (period_start)    gate_q <= 1'b1;
      else if (gate_q && cut)   gate_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        blank_q <= '0;
    else if (enable && period_start)   blank_q <= BLANK_INIT;
    else if (!blank_done)              blank_q <= blank_q - 1'b1;
  end

  assign gate = gate_q && enable && !ilim_trip;

endmodule

// File: rtl/pwm_gate_timer.sv
module pwm_gate_timer
  import pwm_gate_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int DT_W      = 8,
  parameter int BLANK_CYC = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            osc_tick,
  input  logic            sync_tick,
  input  logic            sync_sel,
  input  logic            duty_mode,
  input  logic            pwm_trip,
  input  logic            ilim_trip,
  input  logic [DT_W-1:0] dead_cnt,
  output logic            gate,
  output logic            ilim_pulse
);

  logic             eff_tick;
  logic             period_start, off_tick, final_on, len_valid;
  logic [CNT_W-1:0] cyc, last_len;
  logic             gate_q;

  pwm_tick_select #(.CNT_W(CNT_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_tick  (osc_tick),
    .sync_tick (sync_tick),
    .sync_sel  (sync_sel),
    .eff_tick  (eff_tick)
  );

  pwm_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .tick         (eff_tick),
    .mode         (duty_mode_e'(duty_mode)),
    .period_start (period_start),
    .off_tick     (off_tick),
    .final_on     (final_on),
    .cyc          (cyc),
    .last_len     (last_len),
    .len_valid    (len_valid)
  );

  pwm_gate_ctl #(.CNT_W(CNT_W), .DT_W(DT_W), .BLANK_CYC(BLANK_CYC)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .period_start (period_start),
    .off_tick     (off_tick),
    .final_on     (final_on),
    .cyc          (cyc),
    .last_len     (last_len),
    .len_valid    (len_valid),
    .dead_cnt     (dead_cnt),
    .pwm_trip     (pwm_trip),
    .ilim_trip    (ilim_trip),
    .gate_q       (gate_q),
    .gate         (gate),
    .ilim_pulse   (ilim_pulse)
  );

endmodule

// File: rtl/pwm_gate_checker.sv
module pwm_gate_checker #(
  parameter int BLANK_CYC = 18
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic eff_tick,
  input logic pwm_trip,
  input logic ilim_trip,
  input logic gate_q,
  input logic gate,
  input logic ilim_pulse
);

  logic [15:0] on_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        on_cnt <= '0;
    else if (!gate_q)  on_cnt <= '0;
    else if (on_cnt != 16'hFFFF) on_cnt <= on_cnt + 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |-> (!gate && !ilim_pulse));

  assert_rise_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> $past(eff_tick));

  assert_blank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && enable && !ilim_trip && !eff_tick && (int'(on_cnt) < BLANK_CYC)) |=> gate_q);

  assert_ilim_now_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_trip |-> !gate);

  assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_pulse |-> $past(ilim_trip));

  assert_stay_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_q && !eff_tick) |=> !gate_q);

  assert_disable_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !gate);

  // pwm_trip is observed by the R4 and R5 behaviour; referenced to keep the view complete
  assert_trip_known_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(pwm_trip));

endmodule

bind pwm_gate_timer pwm_gate_checker #(.BLANK_CYC(BLANK_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .eff_tick   (eff_tick),
  .pwm_trip   (pwm_trip),
  .ilim_trip  (ilim_trip),
  .gate_q     (gate_q),
  .gate       (gate),
  .ilim_pulse (ilim_pulse)
);

// File: tb/tb_pwm_gate_timer.sv
`timescale 1ns/1ps
module tb_pwm_gate_timer;

  localparam int BLANK = 18;
  localparam int NV = 7;
  // mode, tick interval, dead time, expected high cycles, expected period
  localparam int VEC [NV][5] = '{
    '{0, 40,  0,  40,  80},
    '{1, 40,  0, 120, 160},
    '{0, 40, 10,  30,  80},
    '{1, 30,  5,  85, 120},
    '{0, 25,  0,  25,  50},
    '{1, 50, 20, 130, 200},
    '{0, 40, 35,  19,  80}
  };

  logic clk = 0, rst_n = 0, enable = 0;
  logic osc_tick = 0, sync_tick = 0, sync_sel = 0, duty_mode = 0;
  logic pwm_trip = 0, ilim_trip = 0;
  logic [7:0] dead_cnt = 0;
  logic gate, ilim_pulse;

  int checks = 0, errors = 0;
  int osc_p = 40, sync_p = 30;
  bit sync_on = 0, finished = 0;

  always #2 clk = ~clk;

  pwm_gate_timer dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .osc_tick(osc_tick),
    .sync_tick(sync_tick), .sync_sel(sync_sel), .duty_mode(duty_mode),
    .pwm_trip(pwm_trip), .ilim_trip(ilim_trip), .dead_cnt(dead_cnt),
    .gate(gate), .ilim_pulse(ilim_pulse)
  );

  initial begin : osc_gen
    int oc = 0;
    forever begin
      @(negedge clk);
      osc_tick = 0;
      if (oc >= osc_p - 1) begin oc = 0; osc_tick = 1; end else oc++;
    end
  end

  initial begin : sync_gen
    int sc = 0;
    forever begin
      @(negedge clk);
      sync_tick = 0;
      if (sync_on) begin
        if (sc >= sync_p - 1) begin sc = 0; sync_tick = 1; end else sc++;
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise(output bit ok);
    bit p;
    ok = 0;
    @(negedge clk);
    p = gate;
    for (int t = 0; t < 5000; t++) begin
      @(negedge clk);
      if (gate && !p) begin ok = 1; return; end
      p = gate;
    end
  endtask

  task automatic measure(output int hi, output int per);
    bit ok, p, done;
    wait_rise(ok);
    hi = 0; per = 0;
    if (!ok) return;
    hi = 1; per = 1; p = 1; done = 0;
    for (int t = 0; t < 5000 && !done; t++) begin
      @(negedge clk);
      if (gate && !p) done = 1;
      else begin per++; if (gate) hi++; end
      p = gate;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int hi, per, cnt;
    bit ok;
    // R1: quiet while reset is held
    repeat (3) @(negedge clk);
    chk(gate == 0, "R1 gate", gate, 0);
    enable = 1;
    repeat (100) @(negedge clk);
    chk(gate == 0, "R1 gate under enable", gate, 0);
    chk(ilim_pulse == 0, "R1 ilim_pulse", ilim_pulse, 0);
    rst_n = 1;

    // table walk: R2, R3, R8 (and R4 minimum on-time in the last row)
    for (int v = 0; v < NV; v++) begin
      duty_mode = VEC[v][0][0];
      osc_p     = VEC[v][1];
      dead_cnt  = 8'(VEC[v][2]);
      repeat (3) measure(hi, per);
      measure(hi, per);
      chk(hi == VEC[v][3], $sformatf("R2/R3/R8 vec%0d high", v), hi, VEC[v][3]);
      chk(per == VEC[v][4], $sformatf("R2/R3/R8 vec%0d period", v), per, VEC[v][4]);
    end

    duty_mode = 0; osc_p = 40; dead_cnt = 0;
    repeat (2) measure(hi, per);

    // R4: held pwm_trip gives exactly the minimum on-time
    wait_rise(ok);
    pwm_trip = 1;
    cnt = 1;
    for (int t = 0; t < 100; t++) begin
      @(negedge clk);
      if (!gate) break;
      cnt++;
    end
    pwm_trip = 0;
    chk(cnt == BLANK + 1, "R4 min on-time", cnt, BLANK + 1);

    // R4 blanking, R5 termination, R7 stays low
    wait_rise(ok);
    pwm_trip = 1;
    repeat (5) @(negedge clk);
    chk(gate == 1, "R4 trip ignored in blanking", gate, 1);
    pwm_trip = 0;
    repeat (19) @(negedge clk);
    chk(gate == 1, "R5 before trip", gate, 1);
    pwm_trip = 1;
    @(negedge clk);
    chk(gate == 0, "R5 trip ends pulse", gate, 0);
    pwm_trip = 0;
    repeat (10) @(negedge clk);
    chk(gate == 0, "R7 low after pwm trip", gate, 0);

    // R6 current limit inside blanking, R7
    wait_rise(ok);
    repeat (2) @(negedge clk);
    ilim_trip = 1;
    #1;
    chk(gate == 0, "R6 same-cycle cut", gate, 0);
    @(negedge clk);
    chk(ilim_pulse == 1, "R6 pulse", ilim_pulse, 1);
    ilim_trip = 0;
    @(negedge clk);
    chk(ilim_pulse == 0, "R6 pulse one cycle", ilim_pulse, 0);
    chk(gate == 0, "R7 low after ilim", gate, 0);
    cnt = 0;
    repeat (30) begin @(negedge clk); if (gate) cnt++; end
    chk(cnt == 0, "R7 no re-rise in period", cnt, 0);

    // R9 enable
    wait_rise(ok);
    repeat (3) @(negedge clk);
    enable = 0;
    #1;
    chk(gate == 0, "R9 immediate off", gate, 0);
    cnt = 0;
    repeat (300) begin @(negedge clk); if (gate) cnt++; end
    chk(cnt == 0, "R9 no rise while disabled", cnt, 0);
    enable = 1;
    measure(hi, per);
    measure(hi, per);
    chk(per == 80, "R9 resumes period", per, 80);

    // R10 sync selection
    sync_on = 1; sync_p = 30; sync_sel = 1;
    repeat (4) measure(hi, per);
    measure(hi, per);
    chk(per == 60, "R10 fast sync used period", per, 60);
    chk(hi == 30, "R10 fast sync used high", hi, 30);
    sync_p = 36;
    repeat (4) measure(hi, per);
    measure(hi, per);
    chk(per == 80, "R10 slow sync refused", per, 80);
    sync_sel = 0; sync_on = 0;

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule